// File: doc/BRIEF.md
# DDR Mode Register Capture Unit

This block sits beside a DDR SDRAM command decoder and owns the mode register. On every rising clock edge it samples chip select, the three command strobes, the bank address and eleven address bits. When all four active-low command pins are low, the cycle is a load-register command. Bank address 0 targets the mode register and bank address 1 targets the extended mode register. The unit accepts such a command only if every bank is idle, clock enable was high in this cycle and in the cycle before, and no earlier load is still completing.

An accepted mode-register load stores the eleven address bits as the raw register. If the fields are legal, it also updates the decoded outputs: burst length, burst order, CAS latency counted in half-cycles, and the test-mode level. A one-cycle DLL-reset pulse is raised when bit 8 is set. Commands that break a precondition are dropped and flagged. Reserved codes are stored raw but flagged, and the last legal decode is kept. All outputs are registered and change at the clock edge that samples the command.

Top module: `ddr_mode_capture`

## Requirements
- R1: After reset, modeValid, busy, all flags, dllResetPulse and testMode are 0, rawMode is 0 and the decoded outputs are 0.
- R2: A load command (csN, rasN, casN, weN all 0) with ba=0 that is accepted copies addr into rawMode at that edge and sets modeValid when its fields are legal; modeValid never falls afterwards.
- R3: A load with ba=1 that is accepted changes no mode output. A load with ba=0 is rejected (preconditionFail pulse, rawMode unchanged) until a ba=1 load has been accepted since reset.
- R4: A load with ba=0 or ba=1 is rejected with a one-cycle preconditionFail pulse, and changes nothing, when allBanksIdle is 0 or cke is 0 in the command cycle or in the cycle before.
- R5: An accepted load holds busy high for the two following cycles. Any command seen in those cycles (csN=0 and not rasN=casN=weN=1) is ignored and produces a one-cycle timingViolation pulse.
- R6: Burst-length field addr[2:0]: code 001 gives burstLen 2, 010 gives 4, 011 gives 8. addr[3]=1 sets burstInterleave.
- R7: CAS-latency field addr[6:4]: code 010 gives casHalfCycles 4, 011 gives 6 and 110 gives 5.
- R8: A mode load whose burst-length or CAS-latency code is any other value, or whose addr[10:9] is nonzero, still updates rawMode and testMode. It raises a one-cycle illegalSetting pulse and leaves burstLen, burstInterleave and casHalfCycles at their previous values.
- R9: testMode follows addr[7] of each accepted mode load.
- R10: dllResetPulse is high for exactly one cycle after an accepted mode load with addr[8]=1.
- R11: The mode register can be rewritten any number of times once the busy window has ended, and each legal rewrite replaces the decoded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable from the command bus |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address; 0 = mode register, 1 = extended |
| addr | input | 11 | Address bits carrying the register value |
| allBanksIdle | input | 1 | High when all banks are precharged |
| modeValid | output | 1 | A legal mode load has been accepted |
| rawMode | output | 11 | Last accepted mode register value |
| burstLen | output | 4 | Decoded burst length (2, 4, 8) |
| burstInterleave | output | 1 | 1 = interleaved burst order |
| casHalfCycles | output | 3 | CAS latency in half cycles (4, 5, 6) |
| testMode | output | 1 | Test-mode bit of the last accepted load |
| dllResetPulse | output | 1 | One-cycle DLL reset request |
| busy | output | 1 | Load completion window is active |
| preconditionFail | output | 1 | Pulse: load dropped for idle, CKE or order |
| timingViolation | output | 1 | Pulse: command arrived inside busy window |
| illegalSetting | output | 1 | Pulse: reserved code or bit in accepted load |

## Verification
Two of the unit's functions can meet in one cycle. The first is the busy-window check on a newly arriving command. The second is the legality classification of the load that opened that window. The bench makes a legal load and then issues a load with reserved codes on the very next edge. It expects timingViolation alone, with no illegalSetting and no change to rawMode, because a command inside the window must never reach classification. A second collision, a load that both lacks its precondition and carries reserved codes, must give preconditionFail only.

// File: rtl/ddr_mode_pkg.sv
package ddr_mode_pkg;
  localparam int ADDR_W  = 11;
  localparam int BA_W    = 2;
  localparam int BL_LSB  = 0;
  localparam int BT_BIT  = 3;
  localparam int CL_LSB  = 4;
  localparam int TM_BIT  = 7;
  localparam int DLL_BIT = 8;
  localparam int RSV_LSB = 9;

  typedef struct packed {
    logic loadRaw;
    logic loadDecoded;
  } modeStrobes_t;
endpackage

// File: rtl/mode_field_decode.sv
module mode_field_decode
  import ddr_mode_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] word,
  output logic          fieldsLegal,
  output logic [3:0]    lenOut,
  output logic          orderOut,
  output logic [2:0]    halfOut
);
  logic lenOk, latOk, rsvOk;
  logic [2:0] lenCode, latCode;

  assign lenCode  = word[BL_LSB +: 3];
  assign latCode  = word[CL_LSB +: 3];
  assign orderOut = word[BT_BIT];
  assign rsvOk    = (word[AW-1:RSV_LSB] == '0);

  always_comb begin
    lenOk = 1'b1;
    case (lenCode)
      3'b001:  lenOut = 4'd2;
      3'b010:  lenOut = 4'd4;
      3'b011:  lenOut = 4'd8;
      default: begin lenOut = 4'd0; lenOk = 1'b0; end
    endcase
  end

  always_comb begin
    latOk = 1'b1;
    case (latCode)
      3'b010:  halfOut = 3'd4;
      3'b011:  halfOut = 3'd6;
      3'b110:  halfOut = 3'd5;
      default: begin halfOut = 3'd0; latOk = 1'b0; end
    endcase
  end

  assign fieldsLegal = lenOk && latOk && rsvOk;
endmodule

// File: rtl/mode_datapath.sv
module mode_datapath
  import ddr_mode_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  modeStrobes_t  strb,
  output logic          fieldsLegal,
  output logic          modeValid,
  output logic [AW-1:0] rawMode,
  output logic [3:0]    burstLen,
  output logic          burstInterleave,
  output logic [2:0]    casHalfCycles,
  output logic          testMode,
  output logic          dllResetPulse
);
  logic [3:0] lenNext;
  logic       orderNext;
  logic [2:0] halfNext;

  mode_field_decode #(.AW(AW)) uDecode (
    .word(addr),
    .fieldsLegal(fieldsLegal),
    .lenOut(lenNext),
    .orderOut(orderNext),
    .halfOut(halfNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawMode       <= '0;
      testMode      <= 1'b0;
      dllResetPulse <= 1'b0;
    end else begin
      dllResetPulse <= strb.loadRaw && addr[DLL_BIT];
      if (strb.loadRaw) begin
        rawMode  <= addr;
        testMode <= addr[TM_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeValid       <= 1'b0;
      burstLen        <= '0;
      burstInterleave <= 1'b0;
      casHalfCycles   <= '0;
    end else if (strb.loadDecoded) begin
      modeValid       <= 1'b1;
      burstLen        <= lenNext;
      burstInterleave <= orderNext;
      casHalfCycles   <= halfNext;
    end
  end

  assert_len_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    modeValid |-> (burstLen == 4'd2 || burstLen == 4'd4 || burstLen == 4'd8));
  assert_lat_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    modeValid |-> (casHalfCycles >= 3'd4 && casHalfCycles <= 3'd6));
  assert_keep_decode_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRaw && !strb.loadDecoded) |=> ($stable(burstLen) && $stable(casHalfCycles)));
  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    modeValid |=> modeValid);
  assert_dll_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    dllResetPulse |=> !dllResetPulse);
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import ddr_mode_pkg::*;
#(
  parameter int BW = BA_W,
  parameter int BUSY_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cke,
  input  logic          csN,
  input  logic          rasN,
  input  logic          casN,
  input  logic          weN,
  input  logic [BW-1:0] ba,
  input  logic          allBanksIdle,
  input  logic          fieldsLegal,
  output modeStrobes_t  strb,
  output logic          busy,
  output logic          preconditionFail,
  output logic          timingViolation,
  output logic          illegalSetting
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;
  logic ckePrev, extSeen;
  logic anyCmd, loadCmd, selMode, selExt, preOk;
  logic acceptExt, acceptMode, rejectNow, violNow;

  assign busy    = (busyCnt != '0);
  assign anyCmd  = !csN && !(rasN && casN && weN);
  assign loadCmd = !csN && !rasN && !casN && !weN;
  assign selMode = (ba == BW'(0));
  assign selExt  = (ba == BW'(1));
  assign preOk   = allBanksIdle && cke && ckePrev;

  assign acceptExt  = loadCmd && selExt && !busy && preOk;
  assign acceptMode = loadCmd && selMode && !busy && preOk && extSeen;
  assign rejectNow  = loadCmd && (selMode || selExt) && !busy &&
                      !(preOk && (selExt || extSeen));
  assign violNow    = anyCmd && busy;

  assign strb.loadRaw     = acceptMode;
  assign strb.loadDecoded = acceptMode && fieldsLegal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckePrev          <= 1'b0;
      extSeen          <= 1'b0;
      busyCnt          <= '0;
      preconditionFail <= 1'b0;
      timingViolation  <= 1'b0;
      illegalSetting   <= 1'b0;
    end else begin
      ckePrev          <= cke;
      preconditionFail <= rejectNow;
      timingViolation  <= violNow;
      illegalSetting   <= acceptMode && !fieldsLegal;
      if (acceptExt) extSeen <= 1'b1;
      if (acceptExt || acceptMode) busyCnt <= CNT_W'(BUSY_CYCLES);
      else if (busy)               busyCnt <= busyCnt - 1'b1;
    end
  end

  assert_busy_opens_R5: assert property (@(posedge clk) disable iff (!rstN)
    (acceptExt || acceptMode) |=> busy);
  assert_viol_in_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    timingViolation |-> $past(busy));
  assert_reject_no_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    preconditionFail |-> !$past(strb.loadRaw));
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones({preconditionFail, timingViolation, illegalSetting}) <= 1);
endmodule

// File: rtl/ddr_mode_capture.sv
module ddr_mode_capture
  import ddr_mode_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BA_W,
  parameter int BUSY_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cke,
  input  logic          csN,
  input  logic          rasN,
  input  logic          casN,
  input  logic          weN,
  input  logic [BW-1:0] ba,
  input  logic [AW-1:0] addr,
  input  logic          allBanksIdle,
  output logic          modeValid,
  output logic [AW-1:0] rawMode,
  output logic [3:0]    burstLen,
  output logic          burstInterleave,
  output logic [2:0]    casHalfCycles,
  output logic          testMode,
  output logic          dllResetPulse,
  output logic          busy,
  output logic          preconditionFail,
  output logic          timingViolation,
  output logic          illegalSetting
);
  modeStrobes_t strb;
  logic fieldsLegal;

  mode_ctrl #(.BW(BW), .BUSY_CYCLES(BUSY_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .ba(ba), .allBanksIdle(allBanksIdle),
    .fieldsLegal(fieldsLegal), .strb(strb), .busy(busy),
    .preconditionFail(preconditionFail), .timingViolation(timingViolation),
    .illegalSetting(illegalSetting)
  );

  mode_datapath #(.AW(AW)) uData (
    .clk(clk), .rstN(rstN), .addr(addr), .strb(strb),
    .fieldsLegal(fieldsLegal), .modeValid(modeValid), .rawMode(rawMode),
    .burstLen(burstLen), .burstInterleave(burstInterleave),
    .casHalfCycles(casHalfCycles), .testMode(testMode),
    .dllResetPulse(dllResetPulse)
  );
endmodule

// File: tb/tb_ddr_mode_capture.sv
module tb_ddr_mode_capture;
  logic clk = 1'b0, rstN = 1'b0, cke = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] ba = '0;
  logic [10:0] addr = '0;
  logic allBanksIdle = 1'b1;
  logic modeValid, burstInterleave, testMode, dllResetPulse, busy;
  logic preconditionFail, timingViolation, illegalSetting;
  logic [10:0] rawMode;
  logic [3:0] burstLen;
  logic [2:0] casHalfCycles;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ddr_mode_capture dut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .allBanksIdle(allBanksIdle),
    .modeValid(modeValid), .rawMode(rawMode), .burstLen(burstLen),
    .burstInterleave(burstInterleave), .casHalfCycles(casHalfCycles),
    .testMode(testMode), .dllResetPulse(dllResetPulse), .busy(busy),
    .preconditionFail(preconditionFail), .timingViolation(timingViolation),
    .illegalSetting(illegalSetting)
  );

  // {addr[10:0], illegal, burstLen[3:0], interleave, casHalf[2:0]}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {11'h021, 1'b0, 4'd2, 1'b0, 3'd4},
    {11'h03A, 1'b0, 4'd4, 1'b1, 3'd6},
    {11'h063, 1'b0, 4'd8, 1'b0, 3'd5},
    {11'h020, 1'b1, 4'd8, 1'b0, 3'd5},
    {11'h012, 1'b1, 4'd8, 1'b0, 3'd5},
    {11'h222, 1'b1, 4'd8, 1'b0, 3'd5},
    {11'h02A, 1'b0, 4'd4, 1'b1, 3'd4},
    {11'h027, 1'b1, 4'd4, 1'b1, 3'd4},
    {11'h421, 1'b1, 4'd4, 1'b1, 3'd4},
    {11'h071, 1'b1, 4'd4, 1'b1, 3'd4},
    {11'h0B1, 1'b0, 4'd2, 1'b0, 3'd6},
    {11'h163, 1'b0, 4'd8, 1'b0, 3'd5}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a command at negedge; outputs sampled at the following negedge
  task automatic issue(input logic r, input logic c, input logic w,
                       input logic [1:0] b, input logic [10:0] a);
    csN = 1'b0; rasN = r; casN = c; weN = w; ba = b; addr = a;
    @(negedge clk);
  endtask

  task automatic nop();
    csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
  endtask

  task automatic idle(input int n);
    nop();
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 modeValid", modeValid, 0);
    check("R1 rawMode", rawMode, 0);
    check("R1 flags", {preconditionFail, timingViolation, illegalSetting, busy}, 0);
    check("R1 dll/test", {dllResetPulse, testMode}, 0);
    check("R1 burstLen", burstLen, 0);
    rstN = 1'b1; cke = 1'b1;
    idle(2);

    // R3 mode load before extended load is rejected
    issue(0, 0, 0, 2'd0, 11'h021);
    check("R3 early reject flag", preconditionFail, 1);
    check("R3 early rawMode", rawMode, 0);
    idle(3);

    // R4 banks not idle on extended load
    allBanksIdle = 1'b0;
    issue(0, 0, 0, 2'd1, 11'h000);
    allBanksIdle = 1'b1;
    check("R4 not idle flag", preconditionFail, 1);
    check("R4 not idle busy", busy, 0);
    idle(2);

    // R3 accepted extended load changes nothing, then R5 collision with reserved codes
    issue(0, 0, 0, 2'd1, 11'h7FF);
    check("R3 ext busy", busy, 1);
    check("R3 ext rawMode", rawMode, 0);
    check("R3 ext modeValid", modeValid, 0);
    issue(0, 0, 0, 2'd0, 11'h020);
    check("R5 viol flag", timingViolation, 1);
    check("R5 no illegal", illegalSetting, 0);
    check("R5 rawMode kept", rawMode, 0);
    issue(0, 1, 1, 2'd0, 11'h000);  // an activate-like command, still in window
    check("R5 second viol", timingViolation, 1);
    nop();
    @(negedge clk);
    check("R5 window closed", busy, 0);
    check("R5 viol cleared", timingViolation, 0);
    idle(2);

    // vector table: R2 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      issue(0, 0, 0, 2'd0, v[19:9]);
      check("R2 rawMode", rawMode, v[19:9]);
      check("R2 modeValid", modeValid, 1);
      check("R8 illegalSetting", illegalSetting, v[8]);
      check("R6 burstLen", burstLen, v[7:4]);
      check("R6 interleave", burstInterleave, v[3]);
      check("R7 casHalfCycles", casHalfCycles, v[2:0]);
      check("R9 testMode", testMode, v[16]);
      check("R10 dll pulse", dllResetPulse, v[17]);
      check("R11 busy", busy, 1);
      nop();
      @(negedge clk);
      check("R10 dll falls", dllResetPulse, 0);
      idle(2);
    end

    // R4 cke low the cycle before
    cke = 1'b0;
    @(negedge clk);
    cke = 1'b1;
    issue(0, 0, 0, 2'd0, 11'h021);
    check("R4 cke prev flag", preconditionFail, 1);
    check("R4 cke prev rawMode", rawMode, 11'h163);
    // R4 cke low in command cycle, reserved codes: only precondition flag
    cke = 1'b0;
    issue(0, 0, 0, 2'd0, 11'h700);
    cke = 1'b1;
    check("R4 cke now flag", preconditionFail, 1);
    check("R4 cke now no illegal", illegalSetting, 0);
    check("R4 cke now rawMode", rawMode, 11'h163);
    idle(3);

    // R11 rewrite after window
    issue(0, 0, 0, 2'd0, 11'h032);
    check("R11 rewrite len", burstLen, 4);
    check("R11 rewrite cas", casHalfCycles, 6);
    idle(3);

    finish_run();
  end
endmodule